// File: doc/BRIEF.md
# PCI Configuration Address/Data Port Translator

This block sits on the host side of a PCI bridge and turns host I/O accesses into one of three things: a read or write of a 32-bit configuration address register, an access to the bridge's own configuration register file, or a request to a PCI master engine. The address register holds an enable bit and a bus/device/function/register selector. Accesses through the 32-bit data window are steered by that selector.

For PCI configuration cycles the block builds the address-phase value itself:
- On bus zero, it produces a type 0 cycle with a one-hot IDSEL line taken from the device number.
- On any other bus, it produces a type 1 cycle with the selector copied through.

Targets that cannot be selected leave every IDSEL line low and are flagged, so the PCI side can expect a master abort. Any I/O access the block does not claim is passed to PCI unchanged as an ordinary I/O cycle.

Every access yields its result one clock after it is presented. A dword write to the address register yields no result and updates the register for the next access.

Top module: `cfg_port_xlate`

## Requirements
- R1: After reset the address register is zero and `rd_valid`, `loc_valid` and `pci_valid` are all low.
- R2: A write to I/O 0CF8h with `io_be`=4'hF stores the register with bits 30:24 and 1:0 forced to zero. A read there with `io_be`=4'hF returns the stored value on `rd_data` with `rd_valid` one cycle later.
- R3: An access to 0CF8h with any `io_be` other than 4'hF leaves the address register unchanged. It is forwarded as a PCI I/O cycle (`pci_kind`=0).
- R4: An access to 0CFCh while address bit 31 is 0 is forwarded as a PCI I/O cycle (`pci_kind`=0) with `pci_addr`=32'h0000_0CFC.
- R5: A data-window access with enable set, bus 0, device 0 and function 0 raises only `loc_valid`, with `loc_offset` equal to {register field, 2'b00}.
- R6: With enable set, bus 0 and device N between 1 and 20, the result is `pci_kind`=1 (type 0). `pci_addr` bit 11+N is the only bit set in 31:11, bits 10:2 are copied from the address register, bits 1:0 are 00, and `pci_no_idsel` is 0.
- R7: With enable set, bus 0 and either device above 20 or device 0 with a nonzero function, the result is `pci_kind`=1 with `pci_addr` bits 31:11 all zero and `pci_no_idsel`=1.
- R8: With enable set and a nonzero bus, the result is `pci_kind`=2 (type 1). `pci_addr` is {8'h00, address bits 23:2, 2'b01} and `pci_no_idsel` is 0.
- R9: The write flag, byte enables and write data of a data-window access pass unchanged to whichever side takes it.
- R10: An I/O access to any other address is forwarded as a PCI I/O cycle with `pci_addr` equal to the zero-extended `io_addr`.
- R11: At most one of `rd_valid`, `loc_valid` and `pci_valid` is high in any cycle, and a result appears only one cycle after an accepted access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_valid | input | 1 | Host I/O access present this cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | Dword-aligned I/O byte address |
| io_be | input | 4 | Byte enables |
| io_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Address register read result valid |
| rd_data | output | 32 | Address register read data |
| loc_valid | output | 1 | Local configuration access request |
| loc_write | output | 1 | Local access is a write |
| loc_offset | output | 8 | Local configuration byte offset (dword aligned) |
| loc_be | output | 4 | Local access byte enables |
| loc_wdata | output | 32 | Local write data |
| pci_valid | output | 1 | PCI cycle request |
| pci_kind | output | 2 | 0 = I/O, 1 = config type 0, 2 = config type 1 |
| pci_write | output | 1 | PCI cycle is a write |
| pci_addr | output | 32 | Address-phase value |
| pci_be | output | 4 | PCI byte enables |
| pci_wdata | output | 32 | PCI write data |
| pci_no_idsel | output | 1 | Type 0 cycle with no IDSEL line asserted |

## Verification
The bench builds the block with its default parameters: a 16-bit I/O space, the two ports at 0CF8h and 0CFCh, and 20 selectable devices. These defaults put both ends of the IDSEL range within reach (device 1 on AD12 and device 20 on AD31), together with the first unselectable device 21 and the top device 31. The bench also exercises the local-claim boundary between function 0 and a nonzero function on device 0, and partial-width hits on the address port.

// File: rtl/cfgx_pkg.sv
// Shared types for the configuration port translator.
package cfgx_pkg;
    typedef enum logic [1:0] {
        K_IO   = 2'd0,
        K_CFG0 = 2'd1,
        K_CFG1 = 2'd2
    } pci_kind_e;

    typedef enum logic [1:0] {
        D_NONE = 2'd0,
        D_PCI  = 2'd1,
        D_LOC  = 2'd2,
        D_RD   = 2'd3
    } dest_e;
endpackage

// File: rtl/cfgx_addr_reg.sv
// Configuration address register.
// Holds enable, bus, device, function and register fields. Reserved bits
// are never stored. Assumes wr_en is only raised for full-dword writes.
module cfgx_addr_reg (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] areg
);
    logic [31:0] areg_q;

    // Store the new selector on a qualified write, keeping reserved bits clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            areg_q <= '0;
        else if (wr_en)
            areg_q <= {wdata[31], 7'b0, wdata[23:2], 2'b00};
    end

    assign areg = areg_q;

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(areg_q)); // R3
endmodule

// File: rtl/cfgx_idsel.sv
// One-hot IDSEL decoder for type 0 cycles.
// Device N in 1..MAX_DEV drives line IDSEL_LSB+N. Device 0 and devices
// above MAX_DEV drive nothing. Assumes IDSEL_LSB+MAX_DEV <= 31.
module cfgx_idsel #(
    parameter int IDSEL_LSB = 11,
    parameter int MAX_DEV   = 20,
    parameter int DEV_W     = 5
) (
    input  logic [DEV_W-1:0]      dev,
    output logic [31-IDSEL_LSB:0] lines
);
    localparam int HI_W = 32 - IDSEL_LSB;

    // Each upper address line compares against its own device number.
    for (genvar b = 0; b < HI_W; b++) begin : g_line
        if (b >= 1 && b <= MAX_DEV) begin : g_sel
            assign lines[b] = (dev == DEV_W'(b));
        end else begin : g_off
            assign lines[b] = 1'b0;
        end
    end
endmodule

// File: rtl/cfgx_route.sv
// Access router.
// Classifies one host I/O access against the address register and
// computes destination, cycle kind, PCI address and the no-IDSEL flag.
// Purely combinational.
module cfgx_route
    import cfgx_pkg::*;
#(
    parameter int          IO_W      = 16,
    parameter logic [15:0] ADDR_PORT = 16'h0CF8,
    parameter logic [15:0] DATA_PORT = 16'h0CFC,
    parameter int          MAX_DEV   = 20
) (
    input  logic            io_valid,
    input  logic            io_write,
    input  logic [IO_W-1:0] io_addr,
    input  logic [3:0]      io_be,
    input  logic [31:0]     areg,
    output dest_e           dest,
    output pci_kind_e       kind,
    output logic [31:0]     paddr,
    output logic            no_idsel,
    output logic            areg_wr
);
    localparam int IDSEL_LSB = 11;

    logic [31-IDSEL_LSB:0] lines;
    logic hit_addr, hit_data, cfg_en, bus_zero, is_local;

    cfgx_idsel #(.IDSEL_LSB(IDSEL_LSB), .MAX_DEV(MAX_DEV), .DEV_W(5)) u_idsel (
        .dev   (areg[15:11]),
        .lines (lines)
    );

    assign hit_addr = io_valid && (io_addr[IO_W-1:2] == ADDR_PORT[IO_W-1:2]) && (io_be == 4'hF);
    assign hit_data = io_valid && (io_addr[IO_W-1:2] == DATA_PORT[IO_W-1:2]);
    assign cfg_en   = areg[31];
    assign bus_zero = (areg[23:16] == 8'h00);
    assign is_local = bus_zero && (areg[15:8] == 8'h00);
    assign areg_wr  = hit_addr && io_write;

    // Pick destination, cycle kind and address-phase value for this access.
    always_comb begin
        dest     = D_NONE;
        kind     = K_IO;
        paddr    = 32'(io_addr);
        no_idsel = 1'b0;
        if (!io_valid) begin
            dest = D_NONE;
        end else if (hit_addr) begin
            dest = io_write ? D_NONE : D_RD;
        end else if (hit_data && cfg_en) begin
            if (!bus_zero) begin
                dest  = D_PCI;
                kind  = K_CFG1;
                paddr = {8'h00, areg[23:2], 2'b01};
            end else if (is_local) begin
                dest = D_LOC;
            end else begin
                dest     = D_PCI;
                kind     = K_CFG0;
                paddr    = {lines, areg[10:2], 2'b00};
                no_idsel = (lines == '0);
            end
        end else begin
            dest = D_PCI;
        end
    end
endmodule

// File: rtl/cfg_port_xlate.sv
// Configuration address/data port translator (top).
// Decodes host I/O accesses, keeps the configuration address register and
// issues exactly one registered result per access (none for address
// register writes): a readback, a local config request or a PCI request.
// Synchronous active-low reset; one cycle from access to result.
module cfg_port_xlate
    import cfgx_pkg::*;
#(
    parameter int          IO_W      = 16,
    parameter logic [15:0] ADDR_PORT = 16'h0CF8,
    parameter logic [15:0] DATA_PORT = 16'h0CFC,
    parameter int          MAX_DEV   = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            io_valid,
    input  logic            io_write,
    input  logic [IO_W-1:0] io_addr,
    input  logic [3:0]      io_be,
    input  logic [31:0]     io_wdata,
    output logic            rd_valid,
    output logic [31:0]     rd_data,
    output logic            loc_valid,
    output logic            loc_write,
    output logic [7:0]      loc_offset,
    output logic [3:0]      loc_be,
    output logic [31:0]     loc_wdata,
    output logic            pci_valid,
    output logic [1:0]      pci_kind,
    output logic            pci_write,
    output logic [31:0]     pci_addr,
    output logic [3:0]      pci_be,
    output logic [31:0]     pci_wdata,
    output logic            pci_no_idsel
);
    logic [31:0] areg;
    logic        areg_wr;
    dest_e       dest;
    pci_kind_e   kind;
    logic [31:0] paddr;
    logic        no_idsel;

    cfgx_addr_reg u_areg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (areg_wr),
        .wdata (io_wdata),
        .areg  (areg)
    );

    cfgx_route #(
        .IO_W(IO_W), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT), .MAX_DEV(MAX_DEV)
    ) u_route (
        .io_valid (io_valid),
        .io_write (io_write),
        .io_addr  (io_addr),
        .io_be    (io_be),
        .areg     (areg),
        .dest     (dest),
        .kind     (kind),
        .paddr    (paddr),
        .no_idsel (no_idsel),
        .areg_wr  (areg_wr)
    );

    // Register the result of the current access toward its destination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid     <= 1'b0;
            rd_data      <= '0;
            loc_valid    <= 1'b0;
            loc_write    <= 1'b0;
            loc_offset   <= '0;
            loc_be       <= '0;
            loc_wdata    <= '0;
            pci_valid    <= 1'b0;
            pci_kind     <= K_IO;
            pci_write    <= 1'b0;
            pci_addr     <= '0;
            pci_be       <= '0;
            pci_wdata    <= '0;
            pci_no_idsel <= 1'b0;
        end else begin
            rd_valid     <= (dest == D_RD);
            rd_data      <= areg;
            loc_valid    <= (dest == D_LOC);
            loc_write    <= io_write;
            loc_offset   <= {areg[7:2], 2'b00};
            loc_be       <= io_be;
            loc_wdata    <= io_wdata;
            pci_valid    <= (dest == D_PCI);
            pci_kind     <= kind;
            pci_write    <= io_write;
            pci_addr     <= paddr;
            pci_be       <= io_be;
            pci_wdata    <= io_wdata;
            pci_no_idsel <= no_idsel;
        end
    end

    AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, loc_valid, pci_valid})); // R11
    AST_RESULT_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid || loc_valid || pci_valid) |-> $past(io_valid)); // R11
    AST_T0_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_valid && pci_kind == K_CFG0) |-> ($onehot0(pci_addr[31:11]) && pci_addr[1:0] == 2'b00)); // R6
    AST_NOID_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_valid && pci_no_idsel) |-> (pci_kind == K_CFG0 && pci_addr[31:11] == '0)); // R7
    AST_T1_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_valid && pci_kind == K_CFG1) |-> (pci_addr[1:0] == 2'b01 && pci_addr[31:24] == 8'h00 && !pci_no_idsel)); // R8
endmodule

// File: tb/sim_cfg_port_xlate.sv
module sim_cfg_port_xlate;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int          dest;   // 1 pci, 2 local, 3 readback
        logic [1:0]  kind;
        logic        wr;
        logic [31:0] addr;
        logic [3:0]  be;
        logic [31:0] data;
        logic        noid;
        string       tag;
    } exp_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        io_valid = 0, io_write = 0;
    logic [15:0] io_addr = '0;
    logic [3:0]  io_be = '0;
    logic [31:0] io_wdata = '0;
    logic        rd_valid, loc_valid, loc_write, pci_valid, pci_write, pci_no_idsel;
    logic [31:0] rd_data, loc_wdata, pci_addr, pci_wdata;
    logic [7:0]  loc_offset;
    logic [3:0]  loc_be, pci_be;
    logic [1:0]  pci_kind;

    int checks = 0, failures = 0;
    exp_t sb[$];
    logic [31:0] m_areg = '0;
    bit running = 0;

    cfg_port_xlate u0 (
        .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
        .io_addr(io_addr), .io_be(io_be), .io_wdata(io_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .loc_valid(loc_valid), .loc_write(loc_write), .loc_offset(loc_offset),
        .loc_be(loc_be), .loc_wdata(loc_wdata),
        .pci_valid(pci_valid), .pci_kind(pci_kind), .pci_write(pci_write),
        .pci_addr(pci_addr), .pci_be(pci_be), .pci_wdata(pci_wdata),
        .pci_no_idsel(pci_no_idsel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Driver: present one access for one cycle and push its expected result.
    task automatic acc(input bit w, input logic [15:0] a, input logic [3:0] be,
                       input logic [31:0] d, input string tag);
        exp_t e;
        logic [4:0] dv;
        logic [2:0] fn;
        logic [31:0] hi;
        e.dest = 0; e.kind = 2'd0; e.wr = w; e.addr = {16'h0, a}; e.be = be;
        e.data = d; e.noid = 1'b0; e.tag = tag;
        if (a == 16'h0CF8 && be == 4'hF) begin
            if (w) m_areg = {d[31], 7'b0, d[23:2], 2'b00};
            else begin e.dest = 3; e.data = m_areg; end
        end else if (a == 16'h0CFC && m_areg[31]) begin
            dv = m_areg[15:11]; fn = m_areg[10:8];
            if (m_areg[23:16] != 8'h00) begin
                e.dest = 1; e.kind = 2'd2; e.addr = {8'h00, m_areg[23:2], 2'b01};
            end else if (dv == 5'd0 && fn == 3'd0) begin
                e.dest = 2; e.addr = {24'h0, m_areg[7:2], 2'b00};
            end else begin
                hi = (dv >= 5'd1 && dv <= 5'd20) ? (32'h1 << (11 + int'(dv))) : 32'h0;
                e.dest = 1; e.kind = 2'd1;
                e.addr = hi | {21'h0, m_areg[10:2], 2'b00};
                e.noid = (hi == 32'h0);
            end
        end else begin
            e.dest = 1;
        end
        if (e.dest != 0) sb.push_back(e);
        io_valid = 1; io_write = w; io_addr = a; io_be = be; io_wdata = d;
        @(negedge clk);
        io_valid = 0;
    endtask

    // Monitor: pop and compare each result as it appears.
    always @(negedge clk) begin
        if (running && (rd_valid || loc_valid || pci_valid)) begin
            exp_t e;
            chk($countones({rd_valid, loc_valid, pci_valid}) == 1, "R11 single destination",
                {29'h0, rd_valid, loc_valid, pci_valid}, 32'h0);
            if (sb.size() == 0) begin
                chk(0, "R11 unexpected result", {29'h0, rd_valid, loc_valid, pci_valid}, 32'h0);
            end else begin
                e = sb.pop_front();
                if (e.dest == 3) begin
                    chk(rd_valid, {e.tag, " dest"}, {31'h0, rd_valid}, 32'h1);
                    chk(rd_data == e.data, {e.tag, " rd_data"}, rd_data, e.data);
                end else if (e.dest == 2) begin
                    chk(loc_valid, {e.tag, " dest"}, {31'h0, loc_valid}, 32'h1);
                    chk({loc_write, loc_be, loc_offset} == {e.wr, e.be, e.addr[7:0]},
                        {e.tag, " local wr/be/offset"}, {19'h0, loc_write, loc_be, loc_offset},
                        {19'h0, e.wr, e.be, e.addr[7:0]});
                    if (e.wr) chk(loc_wdata == e.data, {e.tag, " R9 local wdata"}, loc_wdata, e.data);
                end else begin
                    chk(pci_valid, {e.tag, " dest"}, {31'h0, pci_valid}, 32'h1);
                    chk(pci_addr == e.addr, {e.tag, " pci_addr"}, pci_addr, e.addr);
                    chk({pci_kind, pci_no_idsel} == {e.kind, e.noid}, {e.tag, " kind/noid"},
                        {29'h0, pci_kind, pci_no_idsel}, {29'h0, e.kind, e.noid});
                    chk({pci_write, pci_be} == {e.wr, e.be}, {e.tag, " R9 wr/be"},
                        {27'h0, pci_write, pci_be}, {27'h0, e.wr, e.be});
                    if (e.wr) chk(pci_wdata == e.data, {e.tag, " R9 pci wdata"}, pci_wdata, e.data);
                end
            end
        end
    end

    initial begin
        repeat (CLK_PERIOD * 4000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!rd_valid && !loc_valid && !pci_valid, "R1 valids low in reset",
            {29'h0, rd_valid, loc_valid, pci_valid}, 32'h0);
        rst_n = 1;
        @(negedge clk);
        chk(!rd_valid && !loc_valid && !pci_valid, "R1 valids low after reset",
            {29'h0, rd_valid, loc_valid, pci_valid}, 32'h0);
        running = 1;
        acc(0, 16'h0CF8, 4'hF, 32'h0, "R1 address register reset value");
        acc(1, 16'h0CFC, 4'hF, 32'h1234_5678, "R4 window disabled");
        acc(1, 16'h0CF8, 4'hF, 32'hFF00_1A47, "R2 write");
        acc(0, 16'h0CF8, 4'hF, 32'h0, "R2 readback reserved clear");
        acc(1, 16'h0CFC, 4'h6, 32'hCAFE_F00D, "R6 device 3");
        acc(1, 16'h0CF8, 4'hF, 32'h8000_0810, "R6 setup");
        acc(0, 16'h0CFC, 4'hF, 32'h0, "R6 device 1 AD12");
        acc(1, 16'h0CF8, 4'hF, 32'h8000_A7FC, "R6 setup");
        acc(1, 16'h0CFC, 4'h1, 32'h0000_00A5, "R6 device 20 AD31");
        acc(1, 16'h0CF8, 4'hF, 32'h8000_A800, "R7 setup");
        acc(0, 16'h0CFC, 4'hF, 32'h0, "R7 device 21 no IDSEL");
        acc(1, 16'h0CF8, 4'hF, 32'h8000_FF04, "R7 setup");
        acc(0, 16'h0CFC, 4'hF, 32'h0, "R7 device 31 no IDSEL");
        acc(1, 16'h0CF8, 4'hF, 32'h8000_0308, "R7 setup");
        acc(1, 16'h0CFC, 4'hF, 32'h1111_2222, "R7 device 0 function 3");
        acc(1, 16'h0CF8, 4'hF, 32'h8000_0050, "R5 setup");
        acc(1, 16'h0CFC, 4'h3, 32'hDEAD_BEEF, "R5 local write");
        acc(0, 16'h0CFC, 4'h4, 32'h0, "R5 local read");
        acc(1, 16'h0CF8, 4'hF, 32'h8005_1A3C, "R8 setup");
        acc(1, 16'h0CFC, 4'hC, 32'h5A5A_A5A5, "R8 bus 5");
        acc(1, 16'h0CF8, 4'hF, 32'hFFFF_FFFF, "R8 setup");
        acc(0, 16'h0CFC, 4'hF, 32'h0, "R8 bus FF");
        acc(1, 16'h0CF8, 4'h1, 32'h0000_0000, "R3 byte to address port");
        acc(1, 16'h0CF8, 4'h3, 32'h0000_0000, "R3 word to address port");
        acc(0, 16'h0CF8, 4'hF, 32'h0, "R3 register unchanged");
        acc(1, 16'h03F8, 4'h1, 32'h0000_0041, "R10 other port");
        acc(0, 16'h0CF4, 4'hF, 32'h0, "R10 neighbour port");
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R11 all expected results seen", sb.size(), 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule